// File: doc/BRIEF.md
# Two-Wire Slave Memory Front-End

This block is the bus-facing half of a small serial memory. It runs on a fast system clock and oversamples the two-wire clock (SCL) and data (SDA) lines. Each line goes through a two-flop synchronizer and a three-tap majority vote. An edge detector then finds START, STOP and the clock edges. A control-byte decoder answers only to the 4-bit device code `1010`, ignores the three selection bits, and reads the direction from the last bit. The slave pulls SDA low through an open-drain output enable to acknowledge, and it sends read data most significant bit first.

A 7-bit word pointer is loaded by the first byte of a write. Write data bytes go to an external page-write unit through a one-cycle handoff strobe, and a STOP closes the write with a commit pulse. Reads fetch bytes from a 128-byte array through a synchronous read port with one cycle of latency, so the block supports current-address, random and sequential reads. While the page-write unit reports busy, the slave gives no acknowledge at all, so a master can poll until the write cycle ends.

The controller has these states. `ST_IDLE` waits for a START. `ST_CTRL` shifts in the control byte and moves to `ST_CTRL_ACK` on a matching code with busy low, and to `ST_IGNORE` otherwise. From `ST_CTRL_ACK`, a write goes to `ST_ADDR` and a read goes to `ST_RDATA`. `ST_ADDR` moves to `ST_ADDR_ACK` and then to `ST_WDATA`. `ST_WDATA` and `ST_WDATA_ACK` alternate for each data byte; a byte that arrives while busy is high sends the slave to `ST_IGNORE`. `ST_RDATA` shifts out one byte and then enters `ST_RACK`. There, a master acknowledge returns to `ST_RDATA` with the next byte, and a non-acknowledge goes to `ST_IGNORE`. A START in any state jumps to `ST_CTRL`, and a STOP in any state jumps to `ST_IDLE`.

Top module: `twi_mem_slave`

## Requirements
- R1: Coming out of reset, `sda_oe`, `wr_valid`, `wr_commit` and `mem_rd_en` are all low. A START (SDA falls while SCL is high) in any state aborts the transfer and the slave then takes the next eight bits as a control byte. A STOP (SDA rises while SCL is high) sends it idle with SDA released.
- R2: A control byte whose bits 7:4 are `1010` is acknowledged whatever its bits 3:1 hold. Bit 0 set to 1 selects a read and 0 selects a write. Any other code is not acknowledged, and the slave then stays silent (no acknowledge, no data) until the next START or STOP.
- R3: For each received byte it accepts (control, address, write data), the slave holds SDA low (`sda_oe`=1) for the whole ninth clock and releases it after the ninth falling edge.
- R4: If `busy_i` is high when a received byte completes, that byte is not acknowledged, whatever kind of byte it is. A data byte rejected this way is not handed off, and the slave stays silent until the next START or STOP.
- R5: In a write, the byte after the control byte loads bits 6:0 into the word pointer. Each accepted data byte produces one `wr_valid` cycle carrying the pointer and the byte, and the pointer then increases by one.
- R6: A STOP that ends a write with at least one accepted data byte produces exactly one `wr_commit` pulse. A write ended by a repeated START, or one that carried no data, produces none.
- R7: A read sends the byte stored at the pointer, and the pointer increases by one after each byte sent. A current-address read therefore returns the byte after the last byte accessed.
- R8: A random read (a write that carries only the address, then a repeated START and a read control byte) returns the byte at the address just loaded.
- R9: In a read, a master acknowledge (SDA low on the ninth clock) starts the next sequential byte, and the pointer wraps from 127 to 0. A master non-acknowledge ends the read, and SDA then stays released until the next START or STOP.
- R10: Read data leaves the slave most significant bit first, and `sda_oe` changes only while SCL is low.
- R11: A pulse on SCL or SDA that lasts only one system clock is removed by the majority filter and has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_i | input | 1 | Page-write unit busy; blocks all acknowledges |
| mem_rd_en | output | 1 | Read strobe to the byte array |
| mem_rd_addr | output | 7 | Read address (the word pointer) |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| wr_valid | output | 1 | One-cycle handoff of a received write byte |
| wr_addr | output | 7 | Address of the handed-off byte |
| wr_data | output | 8 | Handed-off write byte |
| wr_commit | output | 1 | One-cycle pulse: STOP closed a write that carried data |

## Verification
A line change at a pin reaches the filtered copy 5 clocks later, and the controller acts on it in the next clock. As a result, `sda_oe` moves about 6 clocks after the SCL falling edge that triggers it, and a `wr_valid` or `wr_commit` pulse comes about 6 clocks after the falling edge or the STOP edge that causes it. The bench master changes SDA 5 clocks after its own SCL falling edge and samples the line 5 clocks into each 10-clock high phase, which is 15 clocks after the fall and well after the slave has settled. Handoffs are not checked at a fixed cycle: they are matched in order against a queue of expected address/data pairs, and the commit count is checked only after the STOP phase has ended.

// File: rtl/twi_pkg.sv
package twi_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } twi_state_e;

    localparam logic [3:0] TWI_DEV_CODE = 4'b1010;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   win_q;
    logic                   vote;

    always_comb vote = ($countones(win_q) > (VOTE_TAPS / 2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            win_q  <= {win_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            line_o <= vote;
        end
    end
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        start_o    = scl_f && scl_q && sda_q && !sda_f;
        stop_o     = scl_f && scl_q && !sda_q && sda_f;
        scl_rise_o = scl_f && !scl_q;
        scl_fall_o = !scl_f && scl_q;
    end
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
    import twi_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_f,
    input  logic              busy_i,
    output logic              sda_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_commit
);
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int CODE_W = 4;

    twi_state_e state, nxt;

    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-2:0] tx_sh;
    logic [DATA_W-1:0] tx_buf;
    logic [ADDR_W-1:0] ptr;
    logic              rw_q, more_q, wrote_q, rd_pend;
    logic              byte_end, code_ok;

    always_comb begin
        byte_end    = scl_fall_i && (bitcnt == CNT_W'(DATA_W));
        code_ok     = (rx_sh[DATA_W-1 -: CODE_W] == TWI_DEV_CODE);
        mem_rd_addr = ptr;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_i) begin
            nxt = ST_CTRL;
        end else if (stop_i) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_CTRL:      if (byte_end) nxt = (code_ok && !busy_i) ? ST_CTRL_ACK : ST_IGNORE;
                ST_ADDR:      if (byte_end) nxt = busy_i ? ST_IGNORE : ST_ADDR_ACK;
                ST_WDATA:     if (byte_end) nxt = busy_i ? ST_IGNORE : ST_WDATA_ACK;
                ST_CTRL_ACK:  if (scl_fall_i) nxt = rw_q ? ST_RDATA : ST_ADDR;
                ST_ADDR_ACK:  if (scl_fall_i) nxt = ST_WDATA;
                ST_WDATA_ACK: if (scl_fall_i) nxt = ST_WDATA;
                ST_RDATA:     if (byte_end) nxt = ST_RACK;
                ST_RACK:      if (scl_fall_i) nxt = more_q ? ST_RDATA : ST_IGNORE;
                ST_IDLE:      nxt = ST_IDLE;
                ST_IGNORE:    nxt = ST_IGNORE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            tx_buf    <= '0;
            ptr       <= '0;
            rw_q      <= 1'b0;
            more_q    <= 1'b0;
            wrote_q   <= 1'b0;
            rd_pend   <= 1'b0;
            sda_oe    <= 1'b0;
            mem_rd_en <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            mem_rd_en <= 1'b0;
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            rd_pend   <= mem_rd_en;
            if (rd_pend) tx_buf <= mem_rd_data;

            if (start_i) begin
                bitcnt  <= '0;
                sda_oe  <= 1'b0;
                wrote_q <= 1'b0;
                more_q  <= 1'b0;
            end else if (stop_i) begin
                bitcnt    <= '0;
                sda_oe    <= 1'b0;
                wr_commit <= wrote_q;
                wrote_q   <= 1'b0;
            end else begin
                unique case (state)
                    ST_CTRL, ST_ADDR, ST_WDATA: begin
                        if (scl_rise_i) begin
                            rx_sh  <= {rx_sh[DATA_W-2:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (byte_end) begin
                            bitcnt <= '0;
                            if (state == ST_CTRL && code_ok && !busy_i) begin
                                sda_oe    <= 1'b1;
                                rw_q      <= rx_sh[0];
                                mem_rd_en <= rx_sh[0];
                            end
                            if (state == ST_ADDR && !busy_i) begin
                                sda_oe <= 1'b1;
                                ptr    <= rx_sh[ADDR_W-1:0];
                            end
                            if (state == ST_WDATA && !busy_i) begin
                                sda_oe   <= 1'b1;
                                wr_valid <= 1'b1;
                                wr_addr  <= ptr;
                                wr_data  <= rx_sh;
                                ptr      <= ptr + 1'b1;
                                wrote_q  <= 1'b1;
                            end
                        end
                    end
                    ST_CTRL_ACK, ST_ADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall_i) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            if (state == ST_CTRL_ACK && rw_q) begin
                                sda_oe <= ~tx_buf[DATA_W-1];
                                tx_sh  <= tx_buf[DATA_W-2:0];
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise_i) bitcnt <= bitcnt + 1'b1;
                        if (byte_end) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            more_q <= 1'b0;
                        end else if (scl_fall_i) begin
                            sda_oe <= ~tx_sh[DATA_W-2];
                            tx_sh  <= {tx_sh[DATA_W-3:0], 1'b0};
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise_i && !sda_f) begin
                            more_q    <= 1'b1;
                            mem_rd_en <= 1'b1;
                        end
                        if (scl_fall_i) begin
                            bitcnt <= '0;
                            if (more_q) begin
                                sda_oe <= ~tx_buf[DATA_W-1];
                                tx_sh  <= tx_buf[DATA_W-2:0];
                            end
                        end
                    end
                    ST_IDLE, ST_IGNORE: begin
                        sda_oe <= 1'b0;
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    // R1: a START always leads to control-byte reception
    assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state == ST_CTRL));

    // R1: a STOP idles the slave with SDA released
    assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (state == ST_IDLE && !sda_oe));

    // R4: an acknowledge only starts when busy was low at the decision
    assert_busy_no_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && (state == ST_CTRL_ACK || state == ST_ADDR_ACK || state == ST_WDATA_ACK))
        |-> !$past(busy_i));

    // R5: a handoff happens together with the data acknowledge
    assert_wr_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (state == ST_WDATA_ACK && sda_oe));

    // R6: commit pulses follow a STOP only
    assert_commit_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> ($past(stop_i) && !$past(start_i)));
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              busy_i,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_commit
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, flt_lines;
    logic scl_f, sda_f;
    logic start_e, stop_e, rise_e, fall_e;

    assign raw_lines = {sda_i, scl_i};
    assign scl_f     = flt_lines[0];
    assign sda_f     = flt_lines[1];

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        twi_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .VOTE_TAPS  (VOTE_TAPS)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(flt_lines[g])
        );
    end

    twi_bus_events u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .start_o   (start_e),
        .stop_o    (stop_e),
        .scl_rise_o(rise_e),
        .scl_fall_o(fall_e)
    );

    twi_slave_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_e),
        .stop_i     (stop_e),
        .scl_rise_i (rise_e),
        .scl_fall_i (fall_e),
        .sda_f      (sda_f),
        .busy_i     (busy_i),
        .sda_oe     (sda_oe),
        .mem_rd_en  (mem_rd_en),
        .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_commit  (wr_commit)
    );

    // R10: the slave moves SDA only while the filtered clock is low
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);
endmodule

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1, glitch = 1'b0, busy = 1'b0;
    logic scl_i, sda_line;
    logic sda_oe, mem_rd_en, wr_valid, wr_commit;
    logic [6:0] mem_rd_addr, wr_addr;
    logic [7:0] mem_rd_data = 8'h00, wr_data;

    assign scl_i    = m_scl & ~glitch;
    assign sda_line = m_sda & ~sda_oe;

    twi_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_line), .sda_oe(sda_oe),
        .busy_i(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_commit(wr_commit)
    );

    int n_chk = 0, n_bad = 0, n_commit = 0, n_viol = 0;
    bit done = 1'b0;
    logic [7:0] mem [128];
    logic [7:0] exp_mem [128];
    logic [14:0] exp_q [$];
    logic prev_oe = 1'b0;

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) % 256);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    // array model behind the synchronous read port
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (wr_valid)  mem[wr_addr] <= wr_data;
    end

    // scoreboard monitor for write handoffs (R5) and commit counting
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected handoff", {wr_addr, wr_data}, 0);
                end else begin
                    logic [14:0] e;
                    e = exp_q.pop_front();
                    chk({wr_addr, wr_data} == e, "R5 handoff addr/data", {wr_addr, wr_data}, e);
                end
            end
            if (wr_commit) n_commit++;
            if (sda_oe != prev_oe && scl_i) n_viol++;
            prev_oe <= sda_oe;
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_wr(input logic [6:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
        exp_mem[a] = d;
    endtask

    task automatic bus_start();
        w(5); m_sda = 1'b1; w(5); m_scl = 1'b1; w(10); m_sda = 1'b0; w(10); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        w(5); m_sda = 1'b0; w(5); m_scl = 1'b1; w(10); m_sda = 1'b1; w(20);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input int gbit);
        for (int i = 7; i > 7 - n; i--) begin
            w(5); m_sda = b[i]; w(5); m_scl = 1'b1;
            if (i == gbit) begin
                w(4); glitch = 1'b1; w(1); glitch = 1'b0; w(5);
            end else begin
                w(10);
            end
            m_scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int gbit, output bit acked);
        send_bits(b, 8, gbit);
        w(5); m_sda = 1'b1; w(5); m_scl = 1'b1; w(5);
        acked = (sda_line == 1'b0);
        w(5); m_scl = 1'b0;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] d);
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            w(5); m_sda = 1'b1; w(5); m_scl = 1'b1; w(5);
            d = {d[6:0], sda_line};
            w(5); m_scl = 1'b0;
        end
        w(5); m_sda = mack ? 1'b0 : 1'b1; w(5); m_scl = 1'b1; w(10); m_scl = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i] = pat(i);
            exp_mem[i] = pat(i);
        end
    end

    initial begin
        bit a;
        logic [7:0] d;
        w(4);
        rst_n = 1'b1;
        w(4);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
        chk({wr_valid, wr_commit, mem_rd_en} == 3'b000, "R1 reset strobes",
            {wr_valid, wr_commit, mem_rd_en}, 0);

        // write of two bytes at 0x10 (R2 R3 R5 R6)
        bus_start();
        send_byte(8'hA0, -1, a); chk(a, "R2 write control ack", a, 1);
        send_byte(8'h10, -1, a); chk(a, "R3 address ack", a, 1);
        expect_wr(7'h10, 8'h55);
        send_byte(8'h55, -1, a); chk(a, "R3 data ack", a, 1);
        expect_wr(7'h11, 8'hAA);
        send_byte(8'hAA, -1, a); chk(a, "R5 second data ack", a, 1);
        bus_stop();
        chk(n_commit == 1, "R6 commit after stop", n_commit, 1);

        // don't-care bits set, address only, no commit (R2 R6)
        bus_start();
        send_byte(8'hAE, -1, a); chk(a, "R2 select bits ignored", a, 1);
        send_byte(8'h40, -1, a); chk(a, "R5 pointer load ack", a, 1);
        bus_stop();
        chk(n_commit == 1, "R6 no commit without data", n_commit, 1);

        // wrong device code (R2)
        bus_start();
        send_byte(8'hB1, -1, a); chk(!a, "R2 wrong code no ack", a, 0);
        send_byte(8'h00, -1, a); chk(!a, "R2 silent after wrong code", a, 0);
        bus_stop();

        // random read (R8)
        bus_start();
        send_byte(8'hA0, -1, a);
        send_byte(8'h10, -1, a);
        bus_start();
        send_byte(8'hA1, -1, a); chk(a, "R2 read control ack", a, 1);
        read_byte(1'b0, d); chk(d == exp_mem[16], "R8 random read", d, exp_mem[16]);
        bus_stop();

        // current-address read (R7 R10)
        bus_start();
        send_byte(8'hA1, -1, a);
        read_byte(1'b0, d); chk(d == exp_mem[17], "R7 current read msb first R10", d, exp_mem[17]);
        bus_stop();

        // sequential read across the wrap (R9)
        bus_start();
        send_byte(8'hA0, -1, a);
        send_byte(8'h7E, -1, a);
        bus_start();
        send_byte(8'hA1, -1, a);
        read_byte(1'b1, d); chk(d == exp_mem[126], "R9 seq byte 126", d, exp_mem[126]);
        read_byte(1'b1, d); chk(d == exp_mem[127], "R9 seq byte 127", d, exp_mem[127]);
        read_byte(1'b1, d); chk(d == exp_mem[0], "R9 seq wrap to 0", d, exp_mem[0]);
        read_byte(1'b0, d); chk(d == exp_mem[1], "R9 seq byte 1", d, exp_mem[1]);
        read_byte(1'b0, d); chk(d == 8'hFF, "R9 released after nack", d, 8'hFF);
        bus_stop();

        // busy blocks all acknowledges (R4)
        busy = 1'b1;
        bus_start();
        send_byte(8'hA0, -1, a); chk(!a, "R4 busy control no ack", a, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(8'hA0, -1, a);
        send_byte(8'h50, -1, a); chk(a, "R4 not busy address ack", a, 1);
        busy = 1'b1;
        send_byte(8'h99, -1, a); chk(!a, "R4 busy data no ack", a, 0);
        bus_stop();
        busy = 1'b0;
        chk(n_commit == 1, "R4 rejected data not committed", n_commit, 1);

        // START mid-byte aborts (R1)
        bus_start();
        send_bits(8'hA0, 4, -1);
        bus_start();
        send_byte(8'hA1, -1, a); chk(a, "R1 restart control ack", a, 1);
        read_byte(1'b0, d); chk(d == exp_mem[80], "R1 read after abort", d, exp_mem[80]);
        bus_stop();

        // repeated START discards the write commit (R6)
        bus_start();
        send_byte(8'hA0, -1, a);
        send_byte(8'h20, -1, a);
        expect_wr(7'h20, 8'h33);
        send_byte(8'h33, -1, a);
        bus_start();
        send_byte(8'hA1, -1, a);
        read_byte(1'b0, d); chk(d == exp_mem[33], "R7 read after write", d, exp_mem[33]);
        bus_stop();
        chk(n_commit == 1, "R6 start discards commit", n_commit, 1);

        // one-clock SCL spike during the control byte (R11)
        bus_start();
        send_byte(8'hA0, 5, a); chk(a, "R11 ack despite spike", a, 1);
        send_byte(8'h30, 2, a); chk(a, "R11 address despite spike", a, 1);
        expect_wr(7'h30, 8'h77);
        send_byte(8'h77, -1, a);
        bus_stop();
        chk(n_commit == 2, "R11 commit count", n_commit, 2);
        bus_start();
        send_byte(8'hA0, -1, a);
        send_byte(8'h30, -1, a);
        bus_start();
        send_byte(8'hA1, -1, a);
        read_byte(1'b0, d); chk(d == 8'h77, "R11 readback", d, 8'h77);
        bus_stop();

        chk(exp_q.size() == 0, "R5 all handoffs seen", exp_q.size(), 0);
        chk(n_viol == 0, "R10 sda only moves with scl low", n_viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule